// File: doc/BRIEF.md
# SPI Programmable CRC Unit

This block keeps two running CRC checksums for an SPI peripheral. One covers the bits that are sent and the other covers the bits that are received. The shifter that sits next to it presents one transmit bit and one receive bit on each shift strobe, most significant bit first. On every enabled strobe, both accumulators advance by one bit, using a polynomial that software can program.

A small register port controls the block. It provides:
- a control word that holds the enable bit and the CRC length select (8 or 16 bits),
- a polynomial register,
- two read-only views of the accumulators.

Setting the enable bit zeroes both accumulators, so a new CRC starts from a known value. While a frame is being accumulated, a busy output warns software that an accumulator read may not be settled yet.

Top module: `spi_crc_unit`

## Requirements
- R1: After reset, the block is in this state:
  - control word is 0 (disabled, 8-bit length),
  - polynomial is 0x0007,
  - both accumulators are 0x0000,
  - busy_o is low.
- R2: A write to address 0 loads the control word: bit 0 is the enable and bit 1 selects 16-bit length when set. Each such write with bit 0 set zeroes both accumulators at that edge, even if the block is already enabled. This clear takes priority over a shift in the same cycle.
- R3: A write to address 1 loads the polynomial only when both conditions hold: the enable bit is currently 0, and bit 0 of the written data is 1. Any other write to address 1 leaves the polynomial unchanged, so the stored polynomial is always odd.
- R4: On each edge where shift_i is high and the block is enabled, each accumulator updates in three steps, where the top bit is bit 7 or bit 15 according to the length:
  1. It XORs its input bit with its current top bit.
  2. It shifts left by one.
  3. It XORs in the polynomial if the result of step 1 was 1.
- R5: In 8-bit length, only the low 8 bits of the polynomial take part in the update. Accumulator reads return zero in bits 15:8. With polynomial 0x07, the 9 bytes "123456789" give 0xF4.
- R6: In 16-bit length, all 16 bits of the polynomial and of each accumulator take part. With polynomial 0x1021, the same 9 bytes give 0x31C3.
- R7: While the enable bit is 0, shift strobes change neither the accumulators nor busy_o.
- R8: busy_o behaves as follows:
  - It rises on the edge after an enabled shift.
  - It stays high between strobes of a frame.
  - It falls one clock after the edge that accumulated the strobe marked by last_i.
  - Any control write returns it low.
- R9: reg_rdata_o is combinational from reg_addr_i:
  - address 0 returns {len, en} in bits 1:0 with all other bits zero,
  - address 1 returns the polynomial,
  - address 2 returns the receive accumulator,
  - address 3 returns the transmit accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| shift_i | input | 1 | One-bit shift strobe for both accumulators |
| last_i | input | 1 | Marks the final bit of a frame, valid with shift_i |
| tx_bit_i | input | 1 | Transmitted data bit, MSB first |
| rx_bit_i | input | 1 | Received data bit, MSB first |
| busy_o | output | 1 | Frame accumulation in progress |

## Verification
The bench drives the block in both lengths with random odd polynomials and random frames that have random gaps between strobes. It also runs the two standard check strings, which catch a wrong top-bit choice or masking that a model bug shared with the design could hide.

It targets several interactions:
- A control write with bit 0 set that lands on the same edge as a shift: a design that lets the shift win leaves a nonzero accumulator.
- Polynomial writes made while enabled, and even-valued writes: a design that accepts either of them shows a changed polynomial and wrong CRCs afterwards.
- Strobes while disabled: a design that accumulates them drifts.
- Single-bit frames and gapped frames: a design that drops busy_o a cycle early or late, or holds it after a control write, is flagged on that cycle.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int unsigned CRC_W_DEF = 16;
  localparam int unsigned ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_POLY   = 2'd1,
    ADDR_RXCRC  = 2'd2,
    ADDR_TXCRC  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    BS_IDLE  = 2'd0,
    BS_RUN   = 2'd1,
    BS_DRAIN = 2'd2
  } busy_state_e;
endpackage

// File: rtl/crc_ctrl_regs.sv
module crc_ctrl_regs
  import spi_crc_pkg::*;
#(
  parameter int unsigned        W          = CRC_W_DEF,
  parameter logic [W-1:0]       POLY_RESET = W'(7)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [W-1:0]          wdata_i,
  output logic                  en_o,
  output logic                  len_full_o,
  output logic [W-1:0]          poly_o,
  output logic                  clear_o,
  output logic                  ctrl_wr_o
);
  logic          en_q, len_q;
  logic [W-1:0]  poly_q;
  logic          poly_wr;

  assign ctrl_wr_o = we_i && (addr_i == ADDR_CTRL);
  assign clear_o   = ctrl_wr_o && wdata_i[0];
  // locked while enabled; even values rejected
  assign poly_wr   = we_i && (addr_i == ADDR_POLY) && !en_q && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      len_q  <= 1'b0;
    end else if (ctrl_wr_o) begin
      en_q   <= wdata_i[0];
      len_q  <= wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      poly_q <= POLY_RESET;
    else if (poly_wr) poly_q <= wdata_i;
  end

  assign en_o       = en_q;
  assign len_full_o = len_q;
  assign poly_o     = poly_q;

  a_r3_poly_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poly_q[0] == 1'b1);
  a_r3_poly_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(poly_q));
  a_r2_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CTRL) |=> (en_q == $past(wdata_i[0])));
endmodule

// File: rtl/crc_lane.sv
module crc_lane
  import spi_crc_pkg::*;
#(
  parameter int unsigned W = CRC_W_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic          len_full_i,
  input  logic [W-1:0]  poly_i,
  input  logic          bit_i,
  output logic [W-1:0]  acc_o
);
  localparam int unsigned H = W / 2;

  logic [W-1:0] acc_q, acc_nxt, poly_eff;
  logic         top_bit, fb;

  always_comb begin
    top_bit  = len_full_i ? acc_q[W-1] : acc_q[H-1];
    fb       = bit_i ^ top_bit;
    poly_eff = len_full_i ? poly_i : {{(W-H){1'b0}}, poly_i[H-1:0]};
    acc_nxt  = {acc_q[W-2:0], 1'b0} ^ (fb ? poly_eff : '0);
    if (!len_full_i) acc_nxt[W-1:H] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (step_i)  acc_q <= acc_nxt;
  end

  assign acc_o = acc_q;

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0));
  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(acc_q));
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !len_full_i) |=> (acc_q[W-1:H] == '0));
  a_r4_no_feedback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && len_full_i && (bit_i == acc_q[W-1]))
      |=> (acc_q == {$past(acc_q[W-2:0]), 1'b0}));
endmodule

// File: rtl/crc_busy.sv
module crc_busy
  import spi_crc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic last_i,
  input  logic ctrl_wr_i,
  output logic busy_o
);
  busy_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ctrl_wr_i)              state_d = BS_IDLE;
    else if (step_i)            state_d = last_i ? BS_DRAIN : BS_RUN;
    else if (state_q == BS_DRAIN) state_d = BS_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BS_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q != BS_IDLE);

  a_r8_shift_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ctrl_wr_i) |=> busy_o);
  a_r8_drain_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BS_DRAIN && !step_i && !ctrl_wr_i) |=> !busy_o);
  a_r8_ctrl_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> !busy_o);
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit
  import spi_crc_pkg::*;
#(
  parameter int unsigned  W          = CRC_W_DEF,
  parameter logic [W-1:0] POLY_RESET = W'(7)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [W-1:0]      reg_wdata_i,
  output logic [W-1:0]      reg_rdata_o,
  input  logic              shift_i,
  input  logic              last_i,
  input  logic              tx_bit_i,
  input  logic              rx_bit_i,
  output logic              busy_o
);
  localparam int unsigned H     = W / 2;
  localparam int unsigned LANES = 2;  // 0: rx, 1: tx

  logic          en, len_full, clear, ctrl_wr, step;
  logic [W-1:0]  poly;
  logic [LANES-1:0] lane_bit;
  logic [W-1:0]  acc [LANES];
  logic [W-1:0]  acc_view [LANES];

  assign lane_bit = {tx_bit_i, rx_bit_i};
  assign step     = en && shift_i;

  crc_ctrl_regs #(.W(W), .POLY_RESET(POLY_RESET)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .en_o       (en),
    .len_full_o (len_full),
    .poly_o     (poly),
    .clear_o    (clear),
    .ctrl_wr_o  (ctrl_wr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    crc_lane #(.W(W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clear_i    (clear),
      .step_i     (step),
      .len_full_i (len_full),
      .poly_i     (poly),
      .bit_i      (lane_bit[g]),
      .acc_o      (acc[g])
    );
    assign acc_view[g] = len_full ? acc[g] : {{(W-H){1'b0}}, acc[g][H-1:0]};
  end

  crc_busy u_busy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .last_i    (last_i),
    .ctrl_wr_i (ctrl_wr),
    .busy_o    (busy_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o = {{(W-2){1'b0}}, len_full, en};
      ADDR_POLY:  reg_rdata_o = poly;
      ADDR_RXCRC: reg_rdata_o = acc_view[0];
      default:    reg_rdata_o = acc_view[1];
    endcase
  end

  a_r5_read_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!len_full && reg_addr_i[1]) |-> (reg_rdata_o[W-1:H] == '0));
  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !ctrl_wr && !busy_o) |=> !busy_o);
endmodule

// File: tb/tb_spi_crc_unit.sv
`timescale 1ns/100ps
module tb_spi_crc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        shift = 1'b0, last = 1'b0, tx_b = 1'b0, rx_b = 1'b0;
  logic        busy;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  int m_poly = 16'h0007, m_rx = 0, m_tx = 0, m_bs = 0;
  bit m_en = 1'b0, m_len = 1'b0;

  always #2.5 clk = ~clk;

  spi_crc_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .shift_i(shift),
    .last_i(last), .tx_bit_i(tx_b), .rx_bit_i(rx_b), .busy_o(busy)
  );

  function automatic int crc_bit(int acc, bit b, int poly, bit l16);
    int w    = l16 ? 16 : 8;
    int mask = (1 << w) - 1;
    int r    = (acc << 1) & mask;
    if (b ^ acc[w-1]) r = r ^ (poly & mask);
    return r;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #0.2;
    v = int'(reg_rdata);
  endtask

  task automatic compare_all();
    int v;
    string acc_tag;
    acc_tag = !m_en ? "R7" : (m_len ? "R4 R6" : "R4 R5");
    rd(2'd0, v); chk("R2 R9", "ctrl", v, {30'b0, m_len, m_en});
    rd(2'd1, v); chk("R3", "poly", v, m_poly);
    rd(2'd2, v); chk(acc_tag, "rx crc", v, m_len ? m_rx : (m_rx & 'hFF));
    rd(2'd3, v); chk(acc_tag, "tx crc", v, m_len ? m_tx : (m_tx & 'hFF));
    chk("R8", "busy", int'(busy), (m_bs != 0) ? 1 : 0);
  endtask

  task automatic tick(bit we, logic [1:0] a, logic [15:0] wd,
                      bit sh, bit ls, bit tb, bit rb);
    bit ctrl_wr, poly_wr, step;
    reg_we = we; reg_addr = a; reg_wdata = wd;
    shift = sh; last = ls; tx_b = tb; rx_b = rb;
    @(posedge clk);
    ctrl_wr = we && a == 2'd0;
    poly_wr = we && a == 2'd1 && !m_en && wd[0];
    step    = m_en && sh;
    if (ctrl_wr && wd[0]) begin
      m_rx = 0; m_tx = 0;
    end else if (step) begin
      m_rx = crc_bit(m_rx, rb, m_poly, m_len);
      m_tx = crc_bit(m_tx, tb, m_poly, m_len);
    end
    if (ctrl_wr)       m_bs = 0;
    else if (step)     m_bs = ls ? 2 : 1;
    else if (m_bs == 2) m_bs = 0;
    if (ctrl_wr) begin m_en = wd[0]; m_len = wd[1]; end
    if (poly_wr) m_poly = int'(wd);
    #0.5;
    reg_we = 1'b0; shift = 1'b0; last = 1'b0;
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    tick(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // one frame of n bits MSB first, optional random gaps between strobes
  task automatic frame(int tx_val, int rx_val, int n, int gap_max, bit mark_last);
    for (int i = n - 1; i >= 0; i--) begin
      if (gap_max > 0) idle($urandom_range(gap_max, 0));
      tick(1'b0, 2'd0, 16'h0, 1'b1, mark_last && i == 0, tx_val[i], rx_val[i]);
    end
  endtask

  task automatic check_string(bit l16, logic [15:0] p, int exp, string tag);
    byte unsigned s [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    int v;
    wr(2'd0, 16'h0);
    wr(2'd1, p);
    wr(2'd0, {14'b0, l16, 1'b1});
    for (int k = 0; k < 9; k++) frame(s[k], s[k], 8, 0, 1'b1);
    idle(1);
    rd(2'd2, v); chk(tag, "check string rx", v, exp);
    rd(2'd3, v); chk(tag, "check string tx", v, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    #12;
    @(negedge clk);
    // R1 reset state, still in reset
    rd(2'd0, v); chk("R1", "ctrl at reset", v, 0);
    rd(2'd1, v); chk("R1", "poly at reset", v, 16'h0007);
    rd(2'd2, v); chk("R1", "rx at reset", v, 0);
    rd(2'd3, v); chk("R1", "tx at reset", v, 0);
    chk("R1", "busy at reset", int'(busy), 0);
    rst_n = 1'b1;
    idle(2);

    // R7: strobes while disabled
    frame(16'hA5, 16'h3C, 8, 1, 1'b1);
    idle(2);

    // R5/R6 known check strings
    check_string(1'b0, 16'h0007, 'hF4, "R5");
    check_string(1'b1, 16'h1021, 'h31C3, "R6");

    // R3: write while enabled ignored, even value ignored
    wr(2'd1, 16'h8005);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'h1234);
    wr(2'd1, 16'h8005);

    // R8: single-bit frames, gapped frame, frame without last
    wr(2'd0, 16'h3);
    frame(1, 0, 1, 0, 1'b1);
    idle(2);
    frame(16'hBEEF, 16'h1357, 16, 3, 1'b1);
    idle(3);
    frame(16'h00F0, 16'h0F0F, 6, 2, 1'b0);
    idle(2);

    // R2: enable rewrite clears, beating a same-cycle shift
    tick(1'b1, 2'd0, 16'h3, 1'b1, 1'b0, 1'b1, 1'b1);
    frame(16'h1, 16'hFFFF, 16, 0, 1'b1);
    tick(1'b1, 2'd0, 16'h1, 1'b1, 1'b1, 1'b1, 1'b0);
    frame(16'h5A, 16'hC3, 8, 0, 1'b1);

    // R4 random frames, random odd polynomials, both lengths
    for (int f = 0; f < 60; f++) begin
      bit l16 = $urandom_range(1, 0) != 0;
      if ($urandom_range(2, 0) == 0) begin
        wr(2'd0, 16'h0);
        wr(2'd1, 16'($urandom()) | 16'h1);
        if ($urandom_range(3, 0) == 0) wr(2'd1, 16'($urandom()) & 16'hFFFE);
        wr(2'd0, {14'b0, l16, 1'b1});
      end else if ($urandom_range(3, 0) == 0) begin
        wr(2'd1, 16'($urandom()) | 16'h1);
        wr(2'd0, {14'b0, l16, 1'b1});
      end
      for (int k = 0; k < 3; k++)
        frame(int'($urandom()), int'($urandom()), l16 ? 16 : 8,
              $urandom_range(2, 0), 1'b1);
      if ($urandom_range(5, 0) == 0) begin
        frame(int'($urandom()), int'($urandom()), 5, 1, 1'b0);
        wr(2'd0, {14'b0, l16, 1'b0});
        frame(int'($urandom()), int'($urandom()), 4, 0, 1'b1);
        wr(2'd0, {14'b0, l16, 1'b1});
      end
      idle($urandom_range(2, 0));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule